// File: doc/BRIEF.md
# Bidirectional Octal Latched Transceiver

The block sits between two parallel ports, A and B, and moves data across them in either direction. Each direction has its own bank of storage, one cell per bit, which can either pass its input straight through or keep a value captured earlier. A bank presents its contents on the opposite port under control of its own drive enable. Every direction has three active-low controls: a chip enable, a latch enable and an output enable.

The chip enable gates everything in its direction. While it is high, the bank keeps its contents whatever its latch enable does, and the opposite port is not driven whatever its output enable does. The output enable only controls driving. A bank can therefore be loaded while its outputs are off, and its contents can be shown later.

The ports are split into separate input, output and per-bit drive-enable vectors, so the block can be built in any synthesizable flow. Storage is held in clocked cells that sample on the rising clock edge. The data view of an open bank follows its input in the same cycle. A status output reports when both directions are set to drive at once.

Top module: `octal_latch_xcvr`

## Requirements
- R1: After synchronous reset both banks hold all-zero contents, visible on `b_out`/`a_out` while the matching bank's gate is closed.
- R2: While `ce_ab_n` and `le_ab_n` are both 0, `b_out` equals `a_in` in the same cycle (transparent path).
- R3: A value on `a_in` present at a rising clock edge while the A-to-B gate is open is held on `b_out` once the gate closes, by either `le_ab_n` or `ce_ab_n` going to 1. Later changes of `a_in` have no effect until the gate reopens.
- R4: While `ce_ab_n` is 1, the A-to-B contents do not change whatever `le_ab_n` is, and `b_oe` is all zeros whatever `oe_ab_n` is.
- R5: `b_oe` is all ones exactly when `ce_ab_n` and `oe_ab_n` are both 0, and `b_out` then shows the A-to-B bank view.
- R6: While `oe_ab_n` is 1, `b_oe` is all zeros, yet the bank still loads when its gate is open. The loaded value appears on `b_out` once the output is enabled.
- R7: The B-to-A direction obeys R2 to R6 with `ce_ba_n`, `le_ba_n`, `oe_ba_n`, input `b_in`, outputs `a_out` and `a_oe`.
- R8: `bus_clash` is 1 exactly when `a_oe` and `b_oe` are both nonzero in the same cycle.
- R9: Loading one bank never changes the contents of the other bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; storage samples on the rising edge |
| rst | input | 1 | Synchronous active-high reset, clears both banks |
| a_in | input | W | Resolved value on port A |
| b_in | input | W | Resolved value on port B |
| ce_ab_n | input | 1 | A-to-B chip enable, active low |
| le_ab_n | input | 1 | A-to-B latch enable, active low |
| oe_ab_n | input | 1 | A-to-B output enable, active low |
| ce_ba_n | input | 1 | B-to-A chip enable, active low |
| le_ba_n | input | 1 | B-to-A latch enable, active low |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| a_out | output | W | B-to-A bank view, data for port A |
| a_oe | output | W | Per-bit drive enable for port A |
| b_out | output | W | A-to-B bank view, data for port B |
| b_oe | output | W | Per-bit drive enable for port B |
| bus_clash | output | 1 | Both directions enabled to drive |

## Verification
The transparent path, the drive enables and the clash flag are combinational, so they are due in the same cycle as their stimulus. The bench drives inputs on the falling edge and compares one time unit later. A capture is due one rising edge after the gate is seen open: the reference model updates its stored word on that edge, and the hold value is compared from the next falling edge on. Every cycle compares all five outputs against the model. Directed phases cover reset, capture by latch enable and by chip enable, loading with outputs off, bank independence and contention.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // One direction's control group, all active low as seen on the pins
    typedef struct packed {
        logic ce_n;
        logic le_n;
        logic oe_n;
    } dir_ctl_t;

    typedef enum logic [1:0] {
        BANK_FROZEN  = 2'd0,  // chip enable off
        BANK_HOLD    = 2'd1,  // chip on, latch enable off
        BANK_PASS    = 2'd2   // chip on, latch enable on
    } bank_mode_e;

    function automatic bank_mode_e decode_mode(input dir_ctl_t c);
        if (c.ce_n)      return BANK_FROZEN;
        else if (c.le_n) return BANK_HOLD;
        else             return BANK_PASS;
    endfunction

    function automatic logic gate_open(input dir_ctl_t c);
        return decode_mode(c) == BANK_PASS;
    endfunction

    function automatic logic drive_on(input dir_ctl_t c);
        return !c.ce_n && !c.oe_n;
    endfunction

endpackage

// File: rtl/xcvr_cell.sv
module xcvr_cell (
    input  logic clk,
    input  logic rst,
    input  logic gate,
    input  logic d,
    output logic view
);
    logic held;

    always_ff @(posedge clk) begin
        if (rst)       held <= 1'b0;
        else if (gate) held <= d;
    end

    assign view = gate ? d : held;
endmodule

// File: rtl/xcvr_bank.sv
module xcvr_bank
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  dir_ctl_t     ctl,
    input  logic [W-1:0] din,
    output logic [W-1:0] view,
    output logic [W-1:0] oe
);
    logic gate;
    logic drv;

    assign gate = gate_open(ctl);
    assign drv  = drive_on(ctl);

    for (genvar i = 0; i < W; i++) begin : g_bit
        xcvr_cell u_cell (
            .clk  (clk),
            .rst  (rst),
            .gate (gate),
            .d    (din[i]),
            .view (view[i])
        );
        assign oe[i] = drv;
    end
endmodule

// File: rtl/octal_latch_xcvr.sv
module octal_latch_xcvr
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         ce_ab_n,
    input  logic         le_ab_n,
    input  logic         oe_ab_n,
    input  logic         ce_ba_n,
    input  logic         le_ba_n,
    input  logic         oe_ba_n,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe,
    output logic         bus_clash
);
    dir_ctl_t ctl_ab;
    dir_ctl_t ctl_ba;

    assign ctl_ab = '{ce_n: ce_ab_n, le_n: le_ab_n, oe_n: oe_ab_n};
    assign ctl_ba = '{ce_n: ce_ba_n, le_n: le_ba_n, oe_n: oe_ba_n};

    xcvr_bank #(.W(W)) u_ab (
        .clk  (clk),
        .rst  (rst),
        .ctl  (ctl_ab),
        .din  (a_in),
        .view (b_out),
        .oe   (b_oe)
    );

    xcvr_bank #(.W(W)) u_ba (
        .clk  (clk),
        .rst  (rst),
        .ctl  (ctl_ba),
        .din  (b_in),
        .view (a_out),
        .oe   (a_oe)
    );

    assign bus_clash = (|a_oe) && (|b_oe);
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic         ce_ab_n,
    input logic         le_ab_n,
    input logic         oe_ab_n,
    input logic         ce_ba_n,
    input logic         le_ba_n,
    input logic         oe_ba_n,
    input logic [W-1:0] a_out,
    input logic [W-1:0] a_oe,
    input logic [W-1:0] b_out,
    input logic [W-1:0] b_oe,
    input logic         bus_clash
);
    AST_AB_PASS: assert property (@(posedge clk) disable iff (rst)
        (!ce_ab_n && !le_ab_n) |-> (b_out == a_in)); // R2

    AST_AB_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (!ce_ab_n && !le_ab_n) |=> ((ce_ab_n || le_ab_n) -> (b_out == $past(a_in)))); // R3

    AST_AB_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ce_ab_n || le_ab_n) |=> ((ce_ab_n || le_ab_n) -> $stable(b_out))); // R4

    AST_AB_CE_OFF: assert property (@(posedge clk) disable iff (rst)
        ce_ab_n |-> (b_oe == '0)); // R4

    AST_AB_OE_OFF: assert property (@(posedge clk) disable iff (rst)
        oe_ab_n |-> (b_oe == '0)); // R6

    AST_AB_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (!ce_ab_n && !oe_ab_n) |-> (b_oe == '1)); // R5

    AST_BA_PASS: assert property (@(posedge clk) disable iff (rst)
        (!ce_ba_n && !le_ba_n) |-> (a_out == b_in)); // R7

    AST_BA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ce_ba_n || le_ba_n) |=> ((ce_ba_n || le_ba_n) -> $stable(a_out))); // R7

    AST_BA_OFF: assert property (@(posedge clk) disable iff (rst)
        (ce_ba_n || oe_ba_n) |-> (a_oe == '0)); // R7

    AST_CLASH: assert property (@(posedge clk) disable iff (rst)
        bus_clash == ((a_oe != '0) && (b_oe != '0))); // R8
endmodule

bind octal_latch_xcvr xcvr_checker #(.W(W)) u_xcvr_checker (
    .clk       (clk),
    .rst       (rst),
    .a_in      (a_in),
    .b_in      (b_in),
    .ce_ab_n   (ce_ab_n),
    .le_ab_n   (le_ab_n),
    .oe_ab_n   (oe_ab_n),
    .ce_ba_n   (ce_ba_n),
    .le_ba_n   (le_ba_n),
    .oe_ba_n   (oe_ba_n),
    .a_out     (a_out),
    .a_oe      (a_oe),
    .b_out     (b_out),
    .b_oe      (b_oe),
    .bus_clash (bus_clash)
);

// File: tb/octal_latch_xcvr_bench.sv
`timescale 1ns/1ps
module octal_latch_xcvr_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         ce_ab_n = 1'b1, le_ab_n = 1'b1, oe_ab_n = 1'b1;
    logic         ce_ba_n = 1'b1, le_ba_n = 1'b1, oe_ba_n = 1'b1;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;
    logic         bus_clash;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // reference stored words
    logic [W-1:0] ref_ab = '0, ref_ba = '0;

    always #5 clk = ~clk;

    octal_latch_xcvr #(.W(W)) u_octal_latch_xcvr (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .ce_ab_n(ce_ab_n), .le_ab_n(le_ab_n), .oe_ab_n(oe_ab_n),
        .ce_ba_n(ce_ba_n), .le_ba_n(le_ba_n), .oe_ba_n(oe_ba_n),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
        .bus_clash(bus_clash)
    );

    always @(posedge clk) begin
        if (rst) begin
            ref_ab = '0;
            ref_ba = '0;
        end else begin
            if (!ce_ab_n && !le_ab_n) ref_ab = a_in;
            if (!ce_ba_n && !le_ba_n) ref_ba = b_in;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // full per-cycle comparison against the reference
    task automatic compare_all();
        logic         g_ab, g_ba, d_ab, d_ba;
        logic [W-1:0] e_b, e_a, e_boe, e_aoe;
        g_ab = !ce_ab_n && !le_ab_n;
        g_ba = !ce_ba_n && !le_ba_n;
        d_ab = !ce_ab_n && !oe_ab_n;
        d_ba = !ce_ba_n && !oe_ba_n;
        e_b   = g_ab ? a_in : ref_ab;
        e_a   = g_ba ? b_in : ref_ba;
        e_boe = d_ab ? '1 : '0;
        e_aoe = d_ba ? '1 : '0;
        chk(g_ab ? "R2 b_out pass" : (ce_ab_n ? "R4 b_out frozen" : "R3 b_out held"),
            32'(b_out), 32'(e_b));
        chk("R7 a_out", 32'(a_out), 32'(e_a));
        chk(oe_ab_n ? "R6 b_oe off" : (ce_ab_n ? "R4 b_oe off" : "R5 b_oe on"),
            32'(b_oe), 32'(e_boe));
        chk("R7 a_oe", 32'(a_oe), 32'(e_aoe));
        chk("R8 bus_clash", 32'(bus_clash), 32'(d_ab && d_ba));
    endtask

    // drive on falling edge, compare 1 ns later
    task automatic step(input logic [2:0] cab, input logic [2:0] cba,
                        input logic [W-1:0] av, input logic [W-1:0] bv);
        @(negedge clk);
        {ce_ab_n, le_ab_n, oe_ab_n} = cab;
        {ce_ba_n, le_ba_n, oe_ba_n} = cba;
        a_in = av;
        b_in = bv;
        #1;
        compare_all();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // control triples are {ce_n, le_n, oe_n}
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset contents shown with gates closed, outputs enabled
        step(3'b010, 3'b010, 8'hA5, 8'h5A);
        chk("R1 b_out reset", 32'(b_out), 32'h0);
        chk("R1 a_out reset", 32'(a_out), 32'h0);

        // R2 transparent, then R3 capture by latch enable rising
        step(3'b000, 3'b111, 8'h3C, 8'h00);
        chk("R2 pass", 32'(b_out), 32'h3C);
        step(3'b010, 3'b111, 8'hFF, 8'h00);
        chk("R3 held after le rise", 32'(b_out), 32'h3C);

        // R3 capture by chip enable rising while latch enable stays low
        step(3'b000, 3'b111, 8'h81, 8'h00);
        step(3'b101, 3'b111, 8'h18, 8'h00);
        step(3'b010, 3'b111, 8'h77, 8'h00);
        chk("R3 held after ce rise", 32'(b_out), 32'h81);

        // R4 chip off: latch enable toggling has no effect, no drive
        step(3'b100, 3'b111, 8'h11, 8'h00);
        chk("R4 b_oe off", 32'(b_oe), 32'h0);
        step(3'b110, 3'b111, 8'h22, 8'h00);
        step(3'b010, 3'b111, 8'h33, 8'h00);
        chk("R4 content kept", 32'(b_out), 32'h81);

        // R6 load with outputs off, then show
        step(3'b001, 3'b111, 8'hC3, 8'h00);
        chk("R6 b_oe off while loading", 32'(b_oe), 32'h0);
        step(3'b011, 3'b111, 8'h00, 8'h00);
        step(3'b010, 3'b111, 8'h00, 8'h00);
        chk("R6 loaded value shown", 32'(b_out), 32'hC3);
        chk("R5 b_oe on", 32'(b_oe), 32'hFF);

        // R7 B-to-A capture, R9 A-to-B untouched
        step(3'b011, 3'b000, 8'h00, 8'h96);
        step(3'b010, 3'b010, 8'h00, 8'h01);
        chk("R7 a_out held", 32'(a_out), 32'h96);
        chk("R9 other bank intact", 32'(b_out), 32'hC3);
        chk("R8 clash", 32'(bus_clash), 32'h1);
        step(3'b011, 3'b010, 8'h00, 8'h01);
        chk("R8 no clash", 32'(bus_clash), 32'h0);

        // random phase, compared every cycle
        for (int i = 0; i < 600; i++) begin
            step(3'($urandom), 3'($urandom), W'($urandom), W'($urandom));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule